// File: doc/BRIEF.md
# Sample-Tick Timer and Interrupt Aggregator

This block combines a periodic timer with a small interrupt collector. The timer does not count core clocks: it counts pulses of an external strobe that arrives once per audio sample (48 kHz). A host programs the period in sample ticks. When the programmed number of ticks has elapsed, the timer marks its interrupt as pending and starts the next period at once. A period of 0x60 therefore gives roughly 500 interrupts per second. Reading the timer register is the acknowledge action: it clears the pending timer interrupt. Writing that register loads a new period and restarts the countdown. A value of zero stops the timer.

Four other interrupt sources (fatal error, parity error, PCM output and MIDI) arrive as single-cycle pulses from logic outside the block. Each pulse latches a pending bit. The host clears such a bit by writing a one to it. A per-source enable register and a global enable bit decide whether the pending events reach the single interrupt output. A free-running count of sample ticks can also be read back.

The timer sequencing is a small state machine with two states. TMR_IDLE holds while the period is zero. TMR_COUNT counts ticks down. There are three transitions. "arm" goes from TMR_IDLE to TMR_COUNT on a write of a nonzero period. "halt" goes from TMR_COUNT to TMR_IDLE on a write of zero. "reload" stays in TMR_COUNT: it follows the last tick of a period, or any nonzero write.

Top module: `sample_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero (source, enable, configuration, timer period, sample time) and `irq` is low.
- R2: After a nonzero period P is written to the timer register (sel = 3), timer pending bit 12 of the source register sets on the P-th following tick, and again after every further P ticks.
- R3: With a period of zero the timer stays in TMR_IDLE and never sets bit 12, however many ticks arrive.
- R4: Writing the timer register while counting discards the ticks already counted and restarts the countdown from the newly written value.
- R5: The period field is 18 bits wide (wdata[17:0]). Higher write bits are ignored, and a read of sel = 3 returns the period, zero-extended.
- R6: A read of the timer register (rd_en with sel = 3) clears timer pending bit 12. If the timer fires in the same cycle, the bit stays set.
- R7: Event pulses set source bits at fixed positions: fatal at bit 0, parity at bit 1, PCM-out at bit 5, MIDI at bit 13. Writing the source register (sel = 0) clears each of these bits where wdata holds a one. Zeros have no effect. An event pulse beats a clear in the same cycle.
- R8: Writing a one to bit 12 of the source register does not clear the timer pending bit.
- R9: `irq` is high exactly when the global enable (bit 14 of the configuration register, sel = 2) is set and some source bit is both pending and set in the enable register (sel = 1, same bit layout as the source register).
- R10: The sample-time register (sel = 4) increments by one on every tick and holds otherwise.
- R11: The enable register keeps only bits 0, 1, 5, 12 and 13. The configuration register keeps only bit 14. Unassigned select codes (5 to 7) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per audio sample |
| ev_fatal | input | 1 | Fatal-error event pulse |
| ev_parity | input | 1 | Parity-error event pulse |
| ev_pcmout | input | 1 | PCM-output event pulse |
| ev_midi | input | 1 | MIDI event pulse |
| sel | input | 3 | Register select: 0 source, 1 enable, 2 config, 3 timer, 4 sample time |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe (side effect only on the timer register) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume several things about the inputs. Each event input and `tick` lasts one cycle per occurrence. `rd_en` and `wr_en` are never raised together. A timer write does not coincide with a tick, so the "restart wins" rule for that case is not exercised. The stimulus honours these assumptions. All inputs change only at the falling clock edge, and every strobe is raised for exactly one cycle and then dropped. The two deliberate collisions are driven inside one cycle: an event pulse with a clearing write, and a firing tick with a timer read. They exercise the set-wins rules.

// File: rtl/stirq_pkg.sv
package stirq_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SOURCE = 3'd0,
        SEL_ENABLE = 3'd1,
        SEL_CONFIG = 3'd2,
        SEL_TIMER  = 3'd3,
        SEL_STIME  = 3'd4
    } sel_e;

    localparam int unsigned BIT_FATAL  = 0;
    localparam int unsigned BIT_PARITY = 1;
    localparam int unsigned BIT_PCMOUT = 5;
    localparam int unsigned BIT_TIMER  = 12;
    localparam int unsigned BIT_MIDI   = 13;
    localparam int unsigned BIT_GLOBAL = 14;

    localparam logic [REG_W-1:0] SRC_MAP =
        (REG_W'(1) << BIT_FATAL)  | (REG_W'(1) << BIT_PARITY) |
        (REG_W'(1) << BIT_PCMOUT) | (REG_W'(1) << BIT_TIMER)  |
        (REG_W'(1) << BIT_MIDI);

    localparam logic [REG_W-1:0] CFG_MAP = REG_W'(1) << BIT_GLOBAL;

    typedef enum logic [0:0] {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/stirq_timer.sv
module stirq_timer
    import stirq_pkg::*;
#(
    parameter int unsigned PER_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    output logic [PER_W-1:0] period,
    output logic             fire
);

    localparam logic [PER_W-1:0] CNT_ONE  = PER_W'(1);
    localparam logic [PER_W-1:0] CNT_ZERO = '0;

    tmr_state_e       state_q, state_d;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic             last_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, halt, reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (load && (load_val != CNT_ZERO)) begin
                    state_d = TMR_COUNT;
                end
            end
            TMR_COUNT: begin
                if (load && (load_val == CNT_ZERO)) begin
                    state_d = TMR_IDLE;
                end
            end
        endcase
    end

    // outputs and countdown datapath
    always_comb begin
        last_tick = (state_q == TMR_COUNT) && tick && (cnt_q == CNT_ONE);
        fire      = last_tick && !load;
        cnt_d     = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (state_q == TMR_COUNT && tick) begin
            cnt_d = last_tick ? period_q : (cnt_q - CNT_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (load) begin
                period_q <= load_val;
            end
            cnt_q <= cnt_d;
        end
    end

    assign period = period_q;

endmodule

// File: rtl/stirq_pending.sv
module stirq_pending #(
    parameter int unsigned     W   = 32,
    parameter logic [W-1:0]    MAP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] pend
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        if (MAP[g]) begin : g_live
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (set_vec[g]) begin
                    q <= 1'b1;
                end else if (clr_vec[g]) begin
                    q <= 1'b0;
                end
            end
            assign pend[g] = q;
        end else begin : g_dead
            logic unused_in;
            assign unused_in = set_vec[g] ^ clr_vec[g];
            assign pend[g]   = 1'b0;
        end
    end

endmodule

// File: rtl/stirq_regs.sv
module stirq_regs
    import stirq_pkg::*;
#(
    parameter int unsigned PER_W    = 18,
    parameter int unsigned SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [REG_W-1:0]    wdata,
    input  logic [REG_W-1:0]    pend,
    input  logic [PER_W-1:0]    period,
    output logic [REG_W-1:0]    mask,
    output logic                gen_en,
    output logic [SAMPLE_W-1:0] sample,
    output logic [REG_W-1:0]    rdata
);

    logic [REG_W-1:0]    mask_q;
    logic                gen_q;
    logic [SAMPLE_W-1:0] sample_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gen_q  <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_ENABLE) begin
                mask_q <= wdata & SRC_MAP;
            end
            if (sel == SEL_CONFIG) begin
                gen_q <= wdata[BIT_GLOBAL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else if (tick) begin
            sample_q <= sample_q + SAMPLE_W'(1);
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_SOURCE: rdata = pend;
            SEL_ENABLE: rdata = mask_q;
            SEL_CONFIG: rdata = {{(REG_W-1){1'b0}}, gen_q} << BIT_GLOBAL;
            SEL_TIMER:  rdata = REG_W'(period);
            SEL_STIME:  rdata = REG_W'(sample_q);
            default:    rdata = '0;
        endcase
    end

    assign mask   = mask_q;
    assign gen_en = gen_q;
    assign sample = sample_q;

endmodule

// File: rtl/sample_irq_ctrl.sv
module sample_irq_ctrl
    import stirq_pkg::*;
#(
    parameter int unsigned PER_W    = 18,
    parameter int unsigned SAMPLE_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ev_fatal,
    input  logic                 ev_parity,
    input  logic                 ev_pcmout,
    input  logic                 ev_midi,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic                 irq
);

    localparam logic [REG_W-1:0] TMR_BIT = REG_W'(1) << BIT_TIMER;

    logic [PER_W-1:0]    period_val;
    logic                tmr_fire;
    logic                tmr_load;
    logic                tmr_ack;
    logic                src_wr;
    logic [REG_W-1:0]    set_vec;
    logic [REG_W-1:0]    clr_vec;
    logic [REG_W-1:0]    pend_vec;
    logic [REG_W-1:0]    mask_vec;
    logic                gen_en;
    logic [SAMPLE_W-1:0] sample_cnt;

    assign tmr_load = wr_en && (sel == SEL_TIMER);
    assign tmr_ack  = rd_en && (sel == SEL_TIMER);
    assign src_wr   = wr_en && (sel == SEL_SOURCE);

    always_comb begin
        set_vec             = '0;
        set_vec[BIT_FATAL]  = ev_fatal;
        set_vec[BIT_PARITY] = ev_parity;
        set_vec[BIT_PCMOUT] = ev_pcmout;
        set_vec[BIT_TIMER]  = tmr_fire;
        set_vec[BIT_MIDI]   = ev_midi;
        clr_vec             = src_wr ? (wdata & ~TMR_BIT) : '0;
        clr_vec[BIT_TIMER]  = tmr_ack;
    end

    stirq_timer #(.PER_W(PER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (wdata[PER_W-1:0]),
        .period   (period_val),
        .fire     (tmr_fire)
    );

    stirq_pending #(.W(REG_W), .MAP(SRC_MAP)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend_vec)
    );

    stirq_regs #(.PER_W(PER_W), .SAMPLE_W(SAMPLE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .pend   (pend_vec),
        .period (period_val),
        .mask   (mask_vec),
        .gen_en (gen_en),
        .sample (sample_cnt),
        .rdata  (rdata)
    );

    assign irq = gen_en && (|(pend_vec & mask_vec));

endmodule

// File: rtl/stirq_checker.sv
module stirq_checker
    import stirq_pkg::*;
#(
    parameter int unsigned PER_W    = 18,
    parameter int unsigned SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                ev_fatal,
    input logic                ev_midi,
    input logic [SEL_W-1:0]    sel,
    input logic                wr_en,
    input logic                rd_en,
    input logic [REG_W-1:0]    wdata,
    input logic                irq,
    input logic [REG_W-1:0]    pend,
    input logic [REG_W-1:0]    mask,
    input logic [PER_W-1:0]    period,
    input logic [SAMPLE_W-1:0] sample
);

    AST_TIMER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_TIMER && !tick) |=> !pend[BIT_TIMER]); // R6

    AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && !(wr_en && sel == SEL_TIMER) && !pend[BIT_TIMER]) |=> !pend[BIT_TIMER]); // R3

    AST_FATAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fatal |=> pend[BIT_FATAL]); // R7

    AST_MIDI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_midi |=> pend[BIT_MIDI]); // R7

    AST_TIMER_NOT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[BIT_TIMER] && wr_en && sel == SEL_SOURCE && !rd_en) |=> pend[BIT_TIMER]); // R8

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(pend & mask))); // R9

    AST_SAMPLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sample == $past(sample) + SAMPLE_W'(1))); // R10

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sample)); // R10

    AST_MASK_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & ~SRC_MAP) == '0); // R11

endmodule

bind sample_irq_ctrl stirq_checker #(.PER_W(PER_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ev_fatal (ev_fatal),
    .ev_midi  (ev_midi),
    .sel      (sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .irq      (irq),
    .pend     (pend_vec),
    .mask     (mask_vec),
    .period   (period_val),
    .sample   (sample_cnt)
);

// File: tb/sim_sample_irq_ctrl.sv
module sim_sample_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ev_fatal = 1'b0, ev_parity = 1'b0, ev_pcmout = 1'b0, ev_midi = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t   sb_q[$];
    int      mon_kind = 0;
    int      n_checks = 0;
    int      n_fail = 0;
    int      ticks_sent = 0;
    bit      done = 1'b0;

    always #10 clk = ~clk;

    sample_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ev_fatal(ev_fatal), .ev_parity(ev_parity), .ev_pcmout(ev_pcmout), .ev_midi(ev_midi),
        .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (mon_kind != 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == 1) ? rdata : {31'd0, irq};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ev(input logic [2:0] s, input logic [31:0] d, input logic [3:0] ev);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        {ev_midi, ev_pcmout, ev_parity, ev_fatal} = ev;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
        {ev_midi, ev_pcmout, ev_parity, ev_fatal} = 4'd0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_ev(s, d, 4'd0);
    endtask

    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {ev_midi, ev_pcmout, ev_parity, ev_fatal} = ev;
        @(negedge clk);
        {ev_midi, ev_pcmout, ev_parity, ev_fatal} = 4'd0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            ticks_sent++;
        end
    endtask

    task automatic rd_chk(input logic [2:0] s, input logic [31:0] e, input string tag, input bit with_tick);
        item_t it;
        @(negedge clk);
        it.kind = 1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        sel = s; rd_en = 1'b1; mon_kind = 1;
        if (with_tick) begin
            tick = 1'b1;
            ticks_sent++;
        end
        @(negedge clk);
        rd_en = 1'b0; mon_kind = 0; tick = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = 2; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        mon_kind = 2;
        @(negedge clk);
        mon_kind = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_chk(3'd0, 32'h0, "R1 source", 0);
        rd_chk(3'd1, 32'h0, "R1 enable", 0);
        rd_chk(3'd2, 32'h0, "R1 config", 0);
        rd_chk(3'd3, 32'h0, "R1 period", 0);
        rd_chk(3'd4, 32'h0, "R1 sample", 0);
        irq_chk(1'b0, "R1 irq");

        // R10 / R3 ticks with zero period
        ticks(5);
        rd_chk(3'd4, 32'd5, "R10 sample count", 0);
        rd_chk(3'd0, 32'h0, "R3 idle no timer", 0);

        // R2 periodic firing, R6 acknowledge
        wr(3'd3, 32'd3);
        ticks(2);
        rd_chk(3'd0, 32'h0, "R2 before period", 0);
        ticks(1);
        rd_chk(3'd0, 32'h1000, "R2 fire on 3rd", 0);
        rd_chk(3'd3, 32'd3, "R6 ack read", 0);
        rd_chk(3'd0, 32'h0, "R6 cleared", 0);
        ticks(3);
        rd_chk(3'd0, 32'h1000, "R2 periodic", 0);
        rd_chk(3'd3, 32'd3, "R6 ack read 2", 0);

        // R4 restart
        wr(3'd3, 32'd4);
        ticks(2);
        wr(3'd3, 32'd4);
        ticks(3);
        rd_chk(3'd0, 32'h0, "R4 restarted", 0);
        ticks(1);
        rd_chk(3'd0, 32'h1000, "R4 fire after restart", 0);
        rd_chk(3'd3, 32'd4, "R6 ack read 3", 0);

        // R5 width, R3 stop
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk(3'd3, 32'h0003_FFFF, "R5 period width", 0);
        wr(3'd3, 32'd0);
        ticks(5);
        rd_chk(3'd0, 32'h0, "R3 stopped", 0);

        // R7 event sources
        pulse(4'b0001);
        pulse(4'b0010);
        pulse(4'b0100);
        pulse(4'b1000);
        rd_chk(3'd0, 32'h2023, "R7 all events", 0);
        wr(3'd0, 32'h0001);
        rd_chk(3'd0, 32'h2022, "R7 w1c fatal", 0);
        wr(3'd0, 32'h0);
        rd_chk(3'd0, 32'h2022, "R7 zero write", 0);
        wr_ev(3'd0, 32'h2000, 4'b1000);
        rd_chk(3'd0, 32'h2022, "R7 set beats clear", 0);
        wr(3'd0, 32'h2000);
        rd_chk(3'd0, 32'h0022, "R7 w1c midi", 0);

        // R8 and R6 collision
        wr(3'd3, 32'd1);
        ticks(1);
        rd_chk(3'd0, 32'h1022, "R2 period one", 0);
        wr(3'd0, 32'h1000);
        rd_chk(3'd0, 32'h1022, "R8 timer not w1c", 0);
        rd_chk(3'd3, 32'd1, "R6 read with fire", 1);
        rd_chk(3'd0, 32'h1022, "R6 fire beats ack", 0);
        wr(3'd3, 32'd0);
        rd_chk(3'd3, 32'd0, "R6 final ack", 0);
        rd_chk(3'd0, 32'h0022, "R6 cleared 2", 0);

        // R9 irq gating, R11 layouts
        irq_chk(1'b0, "R9 masked");
        wr(3'd2, 32'h4000);
        irq_chk(1'b0, "R9 global no enable");
        wr(3'd1, 32'h0020);
        irq_chk(1'b1, "R9 pcm enabled");
        wr(3'd2, 32'h0);
        irq_chk(1'b0, "R9 global off");
        wr(3'd2, 32'hFFFF_FFFF);
        rd_chk(3'd2, 32'h4000, "R11 config bits", 0);
        irq_chk(1'b1, "R9 global on");
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h3023, "R11 enable bits", 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h0, "R7 clear all", 0);
        irq_chk(1'b0, "R9 nothing pending");
        pulse(4'b1000);
        irq_chk(1'b1, "R9 midi raises");
        wr(3'd1, 32'h1000);
        irq_chk(1'b0, "R9 midi disabled");
        rd_chk(3'd5, 32'h0, "R11 unmapped select", 0);
        rd_chk(3'd4, ticks_sent, "R10 total ticks", 0);

        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule